// File: doc/BRIEF.md
# Ingress Packet Trace Filter

This block watches the packet stream of one ingress port. For each packet it inspects the opening 160 bits, which cover the header and possibly some payload. It tests them against four masked comparators and gives one verdict per packet. The verdict is one of three: forward the packet normally, forward it and also send a duplicate to a trace port, or discard it. The verdict comes with a bitmap of the comparators that hit and with the trace port number. Other logic acts on that verdict. This block does not replicate, queue or switch the packet.

Packets arrive as 32-bit words, with a start marker on the first word and an end marker on the last. A state machine with three states captures the key. CAP_IDLE waits for a start marker. CAP_GRAB stores the following words until the key is full or the packet ends. CAP_SKIP lets the rest of a long packet pass until its end marker. The transitions are these. The start transition, taken from any state on a start-marked word, goes to CAP_GRAB, or goes directly to CAP_IDLE or CAP_SKIP if that one word already finishes the key. The finish transition leaves CAP_GRAB for CAP_IDLE when the word carries the end marker, or for CAP_SKIP when it is the fifth word. The skip-end transition goes from CAP_SKIP to CAP_IDLE on the end marker. A comparator engine, with no registers of its own, evaluates the finished key, and an output stage registers the verdict. Software loads the comparator values, the care masks, the per-comparator enables, the port enable, the action bit and the trace port through a write-only register port.

Top module: `ptf_top`

## Requirements
- R1: After reset dec_valid is low and every configuration register is zero: the port is disabled, every comparator is disabled, and the trace port is 0.
- R2: The key is made from the word that carries pkt_sop and the next four accepted words, with word i at key bits [32i+31:32i]. Words after the fifth do not change the verdict.
- R3: For every packet, dec_valid is high for exactly one cycle. It rises at the rising edge that follows the edge which accepted the deciding word. The deciding word is the fifth word, or the pkt_eop word if that comes first. This holds for packets sent back to back.
- R4: Comparator c hits only if its enable bit is set and every key bit whose care-mask bit is 1 equals the value bit. A comparator whose mask is all zero hits on every packet while it is enabled.
- R5: In a packet shorter than five words, a cared-about bit that lies in a missing word counts as a mismatch, whatever its value bit. A missing bit that is masked out does not stop a hit.
- R6: While the port enable bit is clear, every verdict is route (dec_action 0) and dec_hits is 0, whatever the comparators hold.
- R7: With the port enabled and at least one hit, dec_action is 1 (copy to trace) when the action bit is 0, and 2 (drop) when the action bit is 1. Bit c of dec_hits is set exactly when comparator c hit.
- R8: With the port enabled and no hit, dec_action is 0 (route) and dec_hits is 0. The code 3 never appears.
- R9: dec_port gives the trace port field that is in effect when the verdict is made.
- R10: The control register is at address 0x00. Bit 0 is the port enable, bit 1 the action bit (1 = drop), bits [11:8] the trace port and bits [19:16] the comparator enables. Value word w of comparator c is at 0x80 + 16c + w, and care-mask word w is at 0x88 + 16c + w, for w from 0 to 4.
- R11: A start-marked word always begins a new capture. An unfinished earlier packet is then abandoned and gets no verdict. Valid words that arrive in CAP_IDLE without a start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| pkt_valid | input | 1 | Packet word present |
| pkt_sop | input | 1 | First word of a packet |
| pkt_eop | input | 1 | Last word of a packet |
| pkt_data | input | 32 | Packet word |
| dec_valid | output | 1 | Verdict strobe, one per packet |
| dec_action | output | 2 | 0 route, 1 route and copy to trace, 2 drop |
| dec_hits | output | 4 | Bitmap of comparators that hit |
| dec_port | output | 4 | Trace port number |

## Verification
The bench builds the block with its defaults: 32-bit words, a five-word key, four comparators and a 4-bit trace port. With these values every comparator can be placed to hit on the first header word alone, on a partly masked fifth word, or across the first three words of a short packet. The bench then varies the tail of long packets to show that it is ignored, and sends one-word packets back to back to test the latency rule under the heaviest traffic. A restarted packet and stray words outside a packet are also sent, to show that neither produces an extra verdict.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
    typedef enum logic [1:0] {
        ACT_ROUTE = 2'd0,
        ACT_COPY  = 2'd1,
        ACT_DROP  = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_GRAB = 2'd1,
        CAP_SKIP = 2'd2
    } cap_st_e;
endpackage

// File: rtl/ptf_cfg_regs.sv
module ptf_cfg_regs #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 5,
    parameter int NUM_CMP   = 4,
    parameter int PORT_W    = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [WORD_W-1:0]                     wr_data,
    output logic                                  port_en,
    output logic                                  act_drop,
    output logic [PORT_W-1:0]                     trace_port,
    output logic [NUM_CMP-1:0]                    cmp_en,
    output logic [NUM_CMP-1:0][WORD_W*NUM_WORDS-1:0] cmp_val,
    output logic [NUM_CMP-1:0][WORD_W*NUM_WORDS-1:0] cmp_mask
);
    localparam int KEY_W       = WORD_W * NUM_WORDS;
    localparam int SLOT_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int CMP_STRIDE  = 2 ** (SLOT_W + 1);
    localparam int MASK_OFS    = 2 ** SLOT_W;
    localparam int REGION      = 2 ** (ADDR_W - 1);
    localparam int PORT_LSB    = 8;
    localparam int CEN_LSB     = 16;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en    <= 1'b0;
            act_drop   <= 1'b0;
            trace_port <= '0;
            cmp_en     <= '0;
        end else if (ctrl_hit) begin
            port_en    <= wr_data[0];
            act_drop   <= wr_data[1];
            trace_port <= wr_data[PORT_LSB +: PORT_W];
            cmp_en     <= wr_data[CEN_LSB +: NUM_CMP];
        end
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam logic [ADDR_W-1:0] VAL_ADDR  = ADDR_W'(REGION + c * CMP_STRIDE + w);
            localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(REGION + c * CMP_STRIDE + MASK_OFS + w);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cmp_val[c][w*WORD_W +: WORD_W]  <= '0;
                    cmp_mask[c][w*WORD_W +: WORD_W] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == VAL_ADDR)
                        cmp_val[c][w*WORD_W +: WORD_W] <= wr_data;
                    if (wr_addr == MASK_ADDR)
                        cmp_mask[c][w*WORD_W +: WORD_W] <= wr_data;
                end
            end
        end
    end

    AST_CEN_ZERO_WHEN_RESET: assert property (@(posedge clk)
        !rst_n |=> (cmp_en == '0 && !port_en)) else $error("config not cleared"); // R1

    logic unused_key;
    assign unused_key = (KEY_W == 0);
endmodule

// File: rtl/ptf_capture.sv
module ptf_capture
    import ptf_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic [WORD_W-1:0]           in_data,
    output logic [WORD_W*NUM_WORDS-1:0] key,
    output logic [NUM_WORDS-1:0]        present,
    output logic                        key_done
);
    localparam int KEY_W = WORD_W * NUM_WORDS;
    localparam int CNT_W = $clog2(NUM_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);
    localparam bit ONE_WORD = (NUM_WORDS == 1);

    cap_st_e          state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             start, grab, finish;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (in_valid && in_sop) begin
            if (in_eop)        state_nx = CAP_IDLE;
            else if (ONE_WORD) state_nx = CAP_SKIP;
            else               state_nx = CAP_GRAB;
        end else begin
            unique case (state)
                CAP_IDLE: state_nx = CAP_IDLE;
                CAP_GRAB: begin
                    if (in_valid && in_eop)             state_nx = CAP_IDLE;
                    else if (in_valid && cnt == LAST)   state_nx = CAP_SKIP;
                end
                CAP_SKIP: begin
                    if (in_valid && in_eop)             state_nx = CAP_IDLE;
                end
                default: state_nx = CAP_IDLE;
            endcase
        end
    end

    always_comb begin
        start  = in_valid && in_sop;
        grab   = in_valid && !in_sop && (state == CAP_GRAB);
        finish = (start && (in_eop || ONE_WORD)) ||
                 (grab && (in_eop || cnt == LAST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key      <= '0;
            present  <= '0;
            cnt      <= '0;
            key_done <= 1'b0;
        end else begin
            key_done <= finish;
            if (start) begin
                key                <= '0;
                key[WORD_W-1:0]    <= in_data;
                present            <= '0;
                present[0]         <= 1'b1;
                cnt                <= CNT_W'(1);
            end else if (grab) begin
                for (int w = 1; w < NUM_WORDS; w++) begin
                    if (cnt == CNT_W'(w)) begin
                        key[w*WORD_W +: WORD_W] <= in_data;
                        present[w]              <= 1'b1;
                    end
                end
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(NUM_WORDS)) else $error("word counter overrun"); // R2
    AST_DONE_HAS_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |-> present[0]) else $error("verdict without a first word"); // R3
    AST_PRESENT_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |-> (((present + 1'b1) & present) == '0)) else $error("gap in key words"); // R5
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_SKIP && !(in_valid && in_sop)) |=> !key_done) else $error("verdict from tail"); // R11

    logic unused_w;
    assign unused_w = (KEY_W == 0);
endmodule

// File: rtl/ptf_match.sv
module ptf_match #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 5,
    parameter int NUM_CMP   = 4
) (
    input  logic [WORD_W*NUM_WORDS-1:0]              key,
    input  logic [NUM_WORDS-1:0]                     present,
    input  logic [NUM_CMP-1:0]                       cmp_en,
    input  logic [NUM_CMP-1:0][WORD_W*NUM_WORDS-1:0] cmp_val,
    input  logic [NUM_CMP-1:0][WORD_W*NUM_WORDS-1:0] cmp_mask,
    output logic [NUM_CMP-1:0]                       hits
);
    localparam int KEY_W = WORD_W * NUM_WORDS;

    logic [KEY_W-1:0] pres_bits;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pres
        assign pres_bits[w*WORD_W +: WORD_W] = {WORD_W{present[w]}};
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        logic [KEY_W-1:0] bit_ok;
        assign bit_ok  = ~cmp_mask[c] | (pres_bits & ~(key ^ cmp_val[c]));
        assign hits[c] = cmp_en[c] && (&bit_ok);
    end
endmodule

// File: rtl/ptf_top.sv
module ptf_top
    import ptf_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 5,
    parameter int NUM_CMP   = 4,
    parameter int PORT_W    = 4,
    parameter int ADDR_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic               pkt_valid,
    input  logic               pkt_sop,
    input  logic               pkt_eop,
    input  logic [WORD_W-1:0]  pkt_data,
    output logic               dec_valid,
    output logic [1:0]         dec_action,
    output logic [NUM_CMP-1:0] dec_hits,
    output logic [PORT_W-1:0]  dec_port
);
    localparam int KEY_W = WORD_W * NUM_WORDS;

    logic                            port_en, act_drop;
    logic [PORT_W-1:0]               trace_port;
    logic [NUM_CMP-1:0]              cmp_en, hits;
    logic [NUM_CMP-1:0][KEY_W-1:0]   cmp_val, cmp_mask;
    logic [KEY_W-1:0]                key;
    logic [NUM_WORDS-1:0]            present;
    logic                            key_done;
    act_e                            act_nx;
    logic [NUM_CMP-1:0]              hits_nx;

    ptf_cfg_regs #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_CMP(NUM_CMP),
        .PORT_W(PORT_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .port_en(port_en), .act_drop(act_drop), .trace_port(trace_port),
        .cmp_en(cmp_en), .cmp_val(cmp_val), .cmp_mask(cmp_mask)
    );

    ptf_capture #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(pkt_valid), .in_sop(pkt_sop),
        .in_eop(pkt_eop), .in_data(pkt_data), .key(key), .present(present),
        .key_done(key_done)
    );

    ptf_match #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_CMP(NUM_CMP)) u_match (
        .key(key), .present(present), .cmp_en(cmp_en), .cmp_val(cmp_val),
        .cmp_mask(cmp_mask), .hits(hits)
    );

    always_comb begin
        hits_nx = port_en ? hits : '0;
        if (!port_en || hits == '0) act_nx = ACT_ROUTE;
        else if (act_drop)          act_nx = ACT_DROP;
        else                        act_nx = ACT_COPY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_action <= ACT_ROUTE;
            dec_hits   <= '0;
            dec_port   <= '0;
        end else begin
            dec_valid <= key_done;
            if (key_done) begin
                dec_action <= act_nx;
                dec_hits   <= hits_nx;
                dec_port   <= trace_port;
            end
        end
    end

    AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_action != 2'd3) else $error("illegal action code"); // R8
    AST_ROUTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_action == ACT_ROUTE) |-> dec_hits == '0) else $error("route with hits"); // R8
    AST_HIT_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_action != ACT_ROUTE) |-> dec_hits != '0) else $error("action without hit"); // R7
    AST_DISABLED_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (key_done && !port_en) |=> (dec_valid && dec_action == ACT_ROUTE)) else $error("disabled port acted"); // R6
endmodule

// File: tb/sim_ptf_top.sv
module sim_ptf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0;
    logic [31:0] pkt_data = '0;
    logic        dec_valid;
    logic [1:0]  dec_action;
    logic [3:0]  dec_hits;
    logic [3:0]  dec_port;

    always #5 clk = ~clk;

    ptf_top #(.WORD_W(32), .NUM_WORDS(5), .NUM_CMP(4), .PORT_W(4), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_data(pkt_data),
        .dec_valid(dec_valid), .dec_action(dec_action), .dec_hits(dec_hits), .dec_port(dec_port)
    );

    typedef struct {
        logic [1:0] act;
        logic [3:0] hits;
        logic [3:0] port;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t        q[$];
    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    logic        b_en = 0, b_drop = 0;
    logic [3:0]  b_port = 0, b_cen = 0;
    logic [159:0] b_val [4];
    logic [159:0] b_mask [4];
    logic [31:0] pw [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: control register layout
    task automatic set_ctrl(input logic en, input logic drop, input logic [3:0] port, input logic [3:0] cen);
        b_en = en; b_drop = drop; b_port = port; b_cen = cen;
        wr(8'h00, {12'd0, cen, 4'd0, port, 6'd0, drop, en});
    endtask

    // R10: comparator value and mask addresses
    task automatic set_cmp(input int c, input logic [159:0] v, input logic [159:0] m);
        b_val[c] = v; b_mask[c] = m;
        for (int w = 0; w < 5; w++) begin
            wr(8'(8'h80 + c * 16 + w), v[w*32 +: 32]);
            wr(8'(8'h88 + c * 16 + w), m[w*32 +: 32]);
        end
    endtask

    task automatic push_expect(input int n, input string tag);
        exp_t e;
        logic [3:0] h;
        h = '0;
        for (int c = 0; c < 4; c++) begin
            bit ok;
            ok = b_cen[c];
            for (int i = 0; i < 160; i++) begin
                if (b_mask[c][i]) begin
                    if (i / 32 >= n) ok = 0;
                    else if (pw[i/32][i%32] != b_val[c][i]) ok = 0;
                end
            end
            h[c] = ok;
        end
        if (!b_en) begin
            e.act = 2'd0; e.hits = 4'd0;
        end else if (h == 4'd0) begin
            e.act = 2'd0; e.hits = 4'd0;
        end else begin
            e.act = b_drop ? 2'd2 : 2'd1; e.hits = h;
        end
        e.port = b_port;
        e.cyc  = cyc + 2;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic send(input int len, input bit eop, input bit expect_dec, input string tag);
        int didx;
        didx = (len < 5) ? len - 1 : 4;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pkt_valid = 1'b1;
            pkt_sop   = (i == 0);
            pkt_eop   = eop && (i == len - 1);
            pkt_data  = pw[i];
            if (expect_dec && i == didx && (eop || len >= 5))
                push_expect(i + 1, tag);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic load_p(input int len, input logic [31:0] tail);
        pw[0] = 32'hA5C3_0F12; pw[1] = 32'h1234_5678; pw[2] = 32'hDEAD_BEEF;
        pw[3] = 32'h0BAD_F00D; pw[4] = 32'hCAFE_0042;
        for (int i = 5; i < 16; i++) pw[i] = tail ^ i;
        if (len < 0) pw[0] = 32'h0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && dec_valid && !done) begin
            if (q.size() == 0) begin
                check(0, "R3", $sformatf("unexpected verdict act=%0d hits=%b exp none", dec_action, dec_hits));
            end else begin
                exp_t e;
                e = q.pop_front();
                check(dec_action == e.act && dec_hits == e.hits && dec_port == e.port && cyc == e.cyc,
                      e.tag,
                      $sformatf("act=%0d hits=%b port=%0d cyc=%0d exp act=%0d hits=%b port=%0d cyc=%0d",
                                dec_action, dec_hits, dec_port, cyc, e.act, e.hits, e.port, e.cyc));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WATCHDOG", "timeout act=x exp finish");
        report();
    end

    initial begin
        for (int c = 0; c < 4; c++) begin b_val[c] = '0; b_mask[c] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0 && dec_action == 2'd0, "R1",
              $sformatf("dec_valid=%0d act=%0d exp 0 0", dec_valid, dec_action));

        // R1: defaults route everything on port 0
        load_p(5, 32'h0); send(5, 1, 1, "R1"); idle(4);

        // comparator 0 keyed on word 0
        set_cmp(0, {128'd0, 32'hA5C3_0F12}, {128'd0, 32'hFFFF_FFFF});
        set_ctrl(0, 0, 4'd7, 4'b0001);
        load_p(5, 32'h0); send(5, 1, 1, "R6"); idle(4);

        set_ctrl(1, 0, 4'd7, 4'b0001);
        load_p(5, 32'h0); send(5, 1, 1, "R7"); idle(4);

        load_p(5, 32'h0); pw[0] = 32'hA5C3_0F13; send(5, 1, 1, "R8"); idle(4);

        set_ctrl(1, 1, 4'd7, 4'b0001);
        load_p(5, 32'h0); send(5, 1, 1, "R7"); idle(4);

        // R2/R4: comparator 1 on low half of word 4, tails vary
        set_cmp(1, {32'h0000_0042, 128'd0}, {32'h0000_FFFF, 128'd0});
        set_ctrl(1, 0, 4'd7, 4'b0010);
        load_p(8, 32'h1111_0000); send(8, 1, 1, "R2"); idle(4);
        load_p(8, 32'h9999_FFFF); send(8, 1, 1, "R2"); idle(4);
        load_p(5, 32'h0); pw[4] = 32'h7777_0042; send(5, 1, 1, "R4"); idle(4);

        // R5: short packets
        set_cmp(2, {32'd0, 32'd0, 96'd0}, {32'd0, 32'hFFFF_FFFF, 96'd0});
        set_ctrl(1, 0, 4'd7, 4'b0100);
        load_p(3, 32'h0); send(3, 1, 1, "R5"); idle(4);
        set_cmp(3, {64'd0, 32'hDEAD_BEEF, 32'h1234_5678, 32'hA5C3_0F12},
                   {64'd0, {3{32'hFFFF_FFFF}}});
        set_ctrl(1, 0, 4'd7, 4'b1100);
        load_p(3, 32'h0); send(3, 1, 1, "R5"); idle(4);

        // R7: several comparators
        set_ctrl(1, 0, 4'd7, 4'b1111);
        load_p(5, 32'h0); send(5, 1, 1, "R7"); idle(4);
        // R4: disabled comparators do not hit
        set_ctrl(1, 0, 4'd7, 4'b0001);
        load_p(5, 32'h0); send(5, 1, 1, "R4"); idle(4);
        // R4: all-zero mask hits anything
        set_cmp(2, '0, '0);
        set_ctrl(1, 0, 4'd9, 4'b0100);
        load_p(5, 32'h0); pw[0] = 32'h0; pw[4] = 32'h5; send(6, 1, 1, "R4"); idle(4);

        // R9: trace port field
        set_ctrl(1, 0, 4'd15, 4'b0001);
        load_p(5, 32'h0); send(5, 1, 1, "R9"); idle(4);

        // R11: restart mid packet, then stray words
        load_p(5, 32'h0); pw[0] = 32'h0; send(2, 0, 0, "R11");
        load_p(5, 32'h0); send(5, 1, 1, "R11"); idle(2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pkt_valid = 1'b1; pkt_sop = 1'b0; pkt_eop = 1'b0; pkt_data = 32'h5555_0000 + i;
        end
        load_p(2, 32'h0); pw[1] = 32'hFFFF_0000; send(2, 1, 1, "R11"); idle(4);

        // R3: back-to-back single-word packets
        for (int k = 0; k < 6; k++) begin
            load_p(1, 32'h0);
            if (k % 2 == 1) pw[0] = 32'h0000_0001 + k;
            send(1, 1, 1, "R3");
        end
        idle(6);

        check(q.size() == 0, "R3", $sformatf("pending=%0d exp 0", q.size()));
        report();
    end
endmodule